// File: doc/BRIEF.md
# RV64 Memory Protection Configuration Bank

This block holds the control state for physical memory protection on a 64-bit hart. Software reaches it through a simple CSR port with an address, write data, a write enable, combinational read data and a combinational illegal-access flag. Two kinds of register are served. Packed configuration registers hold one byte per protection entry, eight bytes to a 64-bit register. Per-entry address registers hold a physical address shifted right by two.

Only even-numbered configuration registers exist. The register number is turned into an array index by subtracting the base and dividing by a stride of two. An odd number, or a number past the implemented entries, raises the illegal flag and changes nothing. Each entry's decoded configuration byte and stored address are driven out in parallel for a downstream access checker. A summary flag tells the checker whether any entry currently selects an address-matching mode. The number of entries is a parameter, either 8 or 16.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After reset every configuration byte, every address register and the summary flag are zero.
- R2: Configuration register 0x3A0 holds entries 0 to 7. Entry i sits at bits (i mod 8)*8+7 down to (i mod 8)*8. All eight bytes, including bits 63:32, are written and read back.
- R3: With 16 entries, configuration register 0x3A2 holds entries 8 to 15 in the same byte order. With 8 entries, 0x3A2 is illegal.
- R4: Odd configuration numbers in 0x3A0 to 0x3AF, and even ones past the implemented entries, raise the illegal flag and read as zero. A write to them changes no state.
- R5: In each configuration byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode and bit 7 is the lock. Bits 6:5 always read zero, so a written byte is stored ANDed with 0x9F.
- R6: Address register 0x3B0+i holds 54 bits (physical address bits 55:2). A read returns the stored value with bits 63:54 zero. 0x3B0+i for i at or above the entry count (up to 0x3EF) is illegal.
- R7: A write to a configuration register leaves unchanged any byte whose lock bit is set. The unlocked bytes of the same register still take the write. The lock clears only on reset.
- R8: A write to the address register of an entry whose lock bit is set is ignored.
- R9: The summary flag is updated by every configuration write. After the write it is 1 exactly when some entry's mode field (bits 4:3) is nonzero.
- R10: The per-entry outputs show each entry's stored configuration byte and address from the cycle after the write.
- R11: Register numbers outside 0x3A0 to 0x3EF read zero, do not raise the illegal flag and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_addr_i | input | 12 | CSR number being accessed |
| csr_wdata_i | input | 64 | Write data |
| csr_we_i | input | 1 | Write strobe, taken at the rising clock edge |
| csr_rdata_o | output | 64 | Read data for csr_addr_i, combinational |
| csr_illegal_o | output | 1 | CSR number lies in the protection window but is not implemented |
| entry_cfg_o | output | 8*NUM_ENTRIES | Configuration byte of entry i at bits 8i+7:8i |
| entry_addr_o | output | 54*NUM_ENTRIES | Address of entry i at bits 54i+53:54i |
| any_active_o | output | 1 | Some entry has a nonzero match mode |

## Verification
The bench sweeps every CSR number from 0x390 to 0x3FF against two instances, one with 16 entries and one with 8. This separates the even and odd decoding and shows where each entry count ends. Configuration registers get byte patterns that differ in every lane. These show whether bytes land at byte offsets rather than bit offsets and whether the upper four bytes survive. All-ones data shows the reserved-bit mask. Single-mode patterns placed in the lowest and highest entry show whether the summary flag covers both registers. The two instances give different summary values for the same writes. Locked bytes sit next to unlocked bytes in one write, which shows that locking acts per byte and reaches the address registers.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam logic [11:0] CFG_BASE   = 12'h3A0;
  localparam logic [11:0] ADDR_BASE  = 12'h3B0;
  localparam logic [11:0] ADDR_LAST  = 12'h3EF;
  localparam int          CFG_STRIDE = 2;
  localparam int          LANES      = 8;
  localparam int          PA_W       = 54;
  localparam logic [7:0]  CFG_WMASK  = 8'h9F;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_BAD  = 2'd3
  } csr_sel_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } entry_cfg_t;
endpackage

// File: rtl/pmp_rst_sync.sv
module pmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pmp_csr_decode.sv
module pmp_csr_decode
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int NUM_GRP = NUM_ENTRIES / LANES,
  localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int ENT_W   = $clog2(NUM_ENTRIES)
) (
  input  logic [11:0]      csr_addr,
  output csr_sel_e         sel,
  output logic [GRP_W-1:0] grp_idx,
  output logic [ENT_W-1:0] ent_idx
);
  logic       in_cfg, in_addr;
  logic [2:0] slot;
  logic [11:0] aoff_full;
  logic [5:0] aoff;

  assign in_cfg    = (csr_addr[11:4] == CFG_BASE[11:4]);
  assign in_addr   = (csr_addr >= ADDR_BASE) && (csr_addr <= ADDR_LAST);
  assign slot      = csr_addr[3:1];          // offset divided by the stride of two
  assign aoff_full = csr_addr - ADDR_BASE;
  assign aoff      = aoff_full[5:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_cfg) begin
      if (csr_addr[0] || (32'(slot) >= NUM_GRP)) sel = SEL_BAD;
      else                                       sel = SEL_CFG;
    end else if (in_addr) begin
      if (32'(aoff) < NUM_ENTRIES) sel = SEL_ADDR;
      else                         sel = SEL_BAD;
    end
  end

  assign grp_idx = slot[GRP_W-1:0];
  assign ent_idx = aoff[ENT_W-1:0];

  logic unused_hi;
  assign unused_hi = ^{slot, aoff_full[11:6], aoff};
endmodule

// File: rtl/pmp_cfg_entry.sv
module pmp_cfg_entry
  import pmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic [7:0] cfg_nxt,
  output logic [7:0] cfg_q
);
  entry_cfg_t cur;
  assign cur = entry_cfg_t'(cfg_q);

  always_comb begin
    cfg_nxt = cfg_q;
    if (wr_en && !cur.lock) cfg_nxt = wr_byte & CFG_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end

  // R7: a locked byte stays frozen until reset
  p_cfg_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] |=> $stable(cfg_q));

  // R5: an accepted write is stored with bits 6:5 cleared
  p_cfg_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cfg_q[7]) |=> (cfg_q == ($past(wr_byte) & 8'h9F)));
endmodule

// File: rtl/pmp_addr_entry.sv
module pmp_addr_entry
  import pmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            locked,
  input  logic [PA_W-1:0] wr_addr,
  output logic [PA_W-1:0] addr_q
);
  logic [PA_W-1:0] addr_nxt;

  always_comb begin
    addr_nxt = addr_q;
    if (wr_en && !locked) addr_nxt = wr_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
  end

  // R8: the address of a locked entry does not move
  p_addr_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(addr_q));
endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int NUM_GRP = NUM_ENTRIES / LANES,
  localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int ENT_W   = $clog2(NUM_ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [11:0]                 csr_addr_i,
  input  logic [63:0]                 csr_wdata_i,
  input  logic                        csr_we_i,
  output logic [63:0]                 csr_rdata_o,
  output logic                        csr_illegal_o,
  output logic [NUM_ENTRIES*8-1:0]    entry_cfg_o,
  output logic [NUM_ENTRIES*PA_W-1:0] entry_addr_o,
  output logic                        any_active_o
);
  if (NUM_ENTRIES != 8 && NUM_ENTRIES != 16) begin : g_bad_count
    $error("NUM_ENTRIES must be 8 or 16");
  end

  logic rst_sync_n;
  pmp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  csr_sel_e         sel;
  logic [GRP_W-1:0] grp_idx;
  logic [ENT_W-1:0] ent_idx;

  pmp_csr_decode #(.NUM_ENTRIES(NUM_ENTRIES)) u_dec (
    .csr_addr(csr_addr_i), .sel(sel), .grp_idx(grp_idx), .ent_idx(ent_idx)
  );

  logic [NUM_GRP-1:0]     grp_we;
  logic [7:0]             cfg_q   [NUM_ENTRIES];
  logic [7:0]             cfg_nxt [NUM_ENTRIES];
  logic [PA_W-1:0]        addr_q  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] mode_on_nxt, mode_on_now;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_we
    assign grp_we[g] = csr_we_i && (sel == SEL_CFG) && (32'(grp_idx) == g);
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    pmp_cfg_entry u_cfg (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_en(grp_we[e / LANES]),
      .wr_byte(csr_wdata_i[(e % LANES)*8 +: 8]),
      .cfg_nxt(cfg_nxt[e]),
      .cfg_q(cfg_q[e])
    );
    pmp_addr_entry u_addr (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_en(csr_we_i && (sel == SEL_ADDR) && (32'(ent_idx) == e)),
      .locked(cfg_q[e][7]),
      .wr_addr(csr_wdata_i[PA_W-1:0]),
      .addr_q(addr_q[e])
    );
    assign mode_on_nxt[e]            = |cfg_nxt[e][4:3];
    assign mode_on_now[e]            = |cfg_q[e][4:3];
    assign entry_cfg_o[e*8 +: 8]     = cfg_q[e];
    assign entry_addr_o[e*PA_W +: PA_W] = addr_q[e];
  end

  // summary flag: next-state then register
  logic cfg_wr_any, active_nxt, active_q;
  assign cfg_wr_any = |grp_we;

  always_comb begin
    active_nxt = active_q;
    if (cfg_wr_any) active_nxt = |mode_on_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) active_q <= 1'b0;
    else             active_q <= active_nxt;
  end
  assign any_active_o = active_q;

  // read path
  always_comb begin
    csr_rdata_o = '0;
    if (sel == SEL_CFG) begin
      for (int e = 0; e < NUM_ENTRIES; e++)
        if ((e / LANES) == 32'(grp_idx)) csr_rdata_o[(e % LANES)*8 +: 8] = cfg_q[e];
    end else if (sel == SEL_ADDR) begin
      for (int e = 0; e < NUM_ENTRIES; e++)
        if (e == 32'(ent_idx)) csr_rdata_o = {{(64-PA_W){1'b0}}, addr_q[e]};
    end
  end
  assign csr_illegal_o = (sel == SEL_BAD);

  logic unused_wdata;
  assign unused_wdata = ^csr_wdata_i[63:PA_W];

  // R4: an illegal write leaves all state alone
  p_illegal_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_we_i && csr_illegal_o) |=> ($stable(entry_cfg_o) && $stable(entry_addr_o)));

  // R9: after a configuration write the flag matches the stored modes
  p_active_track_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_wr_any |=> (any_active_o == (|mode_on_now)));

  // R2: the top byte of the first register is never dropped
  p_upper_byte_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_we_i && csr_addr_i == CFG_BASE && !entry_cfg_o[63])
      |=> (entry_cfg_o[63:56] == ($past(csr_wdata_i[63:56]) & 8'h9F)));
endmodule

// File: tb/pmp_cfg_bank_test.sv
module pmp_cfg_bank_test;
  localparam int N = 16;
  localparam int PW = 54;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic csr_we = 1'b0;

  logic [63:0] rdata, rdata8;
  logic ill, ill8, act, act8;
  logic [N*8-1:0] ecfg;
  logic [N*PW-1:0] eaddr;
  logic [8*8-1:0] ecfg8;
  logic [8*PW-1:0] eaddr8;

  always #2 clk = ~clk;  // 250 MHz

  pmp_cfg_bank #(.NUM_ENTRIES(16)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_rdata_o(rdata), .csr_illegal_o(ill),
    .entry_cfg_o(ecfg), .entry_addr_o(eaddr), .any_active_o(act));

  pmp_cfg_bank #(.NUM_ENTRIES(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
    .csr_we_i(csr_we), .csr_rdata_o(rdata8), .csr_illegal_o(ill8),
    .entry_cfg_o(ecfg8), .entry_addr_o(eaddr8), .any_active_o(act8));

  int total = 0, fails = 0;
  logic [7:0]    m_cfg [N];
  logic [PW-1:0] m_addr[N];

  task automatic chk(input string req, input logic [63:0] a, input logic [63:0] e);
    total++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  function automatic logic exp_ill(input logic [11:0] a, input int n);
    if (a[11:4] == 8'h3A) return a[0] || (int'(a[3:1]) >= n / 8);
    if (a >= 12'h3B0 && a <= 12'h3EF) return int'(a - 12'h3B0) >= n;
    return 1'b0;
  endfunction

  function automatic logic [63:0] grp_val(input int g);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_cfg[g*8 + k];
    return v;
  endfunction

  function automatic logic exp_act(input int n);
    logic r = 1'b0;
    for (int e = 0; e < n; e++) r |= |m_cfg[e][4:3];
    return r;
  endfunction

  task automatic model_reset();
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
    if (a[11:4] == 8'h3A && !a[0] && a[3:1] < 3'd2) begin
      for (int k = 0; k < 8; k++)
        if (!m_cfg[a[1]*8 + k][7]) m_cfg[a[1]*8 + k] = d[k*8 +: 8] & 8'h9F;
    end else if (a >= 12'h3B0 && a < 12'h3C0) begin
      if (!m_cfg[a - 12'h3B0][7]) m_addr[a - 12'h3B0] = d[PW-1:0];
    end
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    csr_addr = a; csr_we = 1'b0;
    #1;
  endtask

  task automatic check_state(input string req);
    rd(12'h3A0); chk({req, " R2 cfg0 read"}, rdata, grp_val(0));
    chk({req, " R3 cfg0 read 8-entry"}, rdata8, grp_val(0));
    rd(12'h3A2); chk({req, " R3 cfg2 read"}, rdata, grp_val(1));
    for (int e = 0; e < N; e++) begin
      rd(12'h3B0 + 12'(e));
      chk({req, " R6 addr read"}, rdata, {10'b0, m_addr[e]});
      chk({req, " R10 entry cfg"}, 64'(ecfg[e*8 +: 8]), 64'(m_cfg[e]));
      chk({req, " R10 entry addr"}, 64'(eaddr[e*PW +: PW]), 64'(m_addr[e]));
    end
    chk({req, " R9 active"}, 64'(act), 64'(exp_act(16)));
    chk({req, " R9 active 8-entry"}, 64'(act8), 64'(exp_act(8)));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired, all requirements, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    check_state("R1 reset");

    // decode sweep on both entry counts (R3 R4 R6 R11)
    for (int a = 12'h390; a <= 12'h3FF; a++) begin
      rd(12'(a));
      chk("R4/R6/R11 illegal flag 16", 64'(ill), 64'(exp_ill(12'(a), 16)));
      chk("R3 illegal flag 8", 64'(ill8), 64'(exp_ill(12'(a), 8)));
      if (exp_ill(12'(a), 16) || a < 12'h3A0 || a > 12'h3EF)
        chk("R4 R11 read zero", rdata, 64'h0);
    end

    // lane-distinct patterns without lock bits (R2 R3 R5)
    for (int p = 0; p < 6; p++) begin
      logic [63:0] d0, d2;
      for (int k = 0; k < 8; k++) begin
        d0[k*8 +: 8] = 8'((p*37 + k*11 + 1) & 8'h7F);
        d2[k*8 +: 8] = 8'((p*53 + k*29 + 5) & 8'h7F);
      end
      wr(12'h3A0, d0);
      wr(12'h3A2, d2);
      check_state("R2 R3 pattern");
    end
    wr(12'h3A0, 64'h7F7F_7F7F_7F7F_7F7F);
    check_state("R5 all-ones mask");

    // summary flag (R9)
    wr(12'h3A0, 64'h0); wr(12'h3A2, 64'h0);
    check_state("R9 all off");
    wr(12'h3A2, 64'h1800_0000_0000_0000);
    check_state("R9 only entry 15");
    wr(12'h3A2, 64'h0); wr(12'h3A0, 64'h0800_0000_0000_0000);
    check_state("R9 only entry 7 R2 upper byte");

    // address registers (R6)
    for (int e = 0; e < N; e++)
      wr(12'h3B0 + 12'(e), {32'hF0E1D2C3 ^ 32'(e * 32'h01010101), 32'h5A5A0000 + 32'(e)});
    check_state("R6 address pattern");

    // illegal and out-of-window writes (R4 R11)
    wr(12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h3A3, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h3C0, 64'h1234);
    check_state("R4 odd write ignored");
    wr(12'h390, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h3F0, 64'hFFFF_FFFF_FFFF_FFFF);
    check_state("R11 outside write ignored");

    // locking (R7 R8)
    wr(12'h3A0, 64'h0000_0000_0098_0000);
    wr(12'h3A2, 64'h8100_0000_0000_0000);
    wr(12'h3A0, 64'h0707_0707_0707_0707);
    wr(12'h3A2, 64'h0707_0707_0707_0707);
    check_state("R7 locked byte kept");
    wr(12'h3B2, 64'h0000_0000_DEAD_BEEF);
    wr(12'h3BF, 64'h0000_0000_0000_0001);
    wr(12'h3B3, 64'h0000_0000_CAFE_0000);
    check_state("R8 locked address kept");

    do_reset();
    check_state("R1 second reset clears locks");

    summary();
    $finish;
  end
endmodule